// File: doc/BRIEF.md
# Comma-Aligned Receive Deserializer

This block sits behind a clock-recovery front end. It takes the recovered serial stream one bit per bit clock and packs the bits into 10-bit characters. The first bit in time becomes bit 0 of the character. A 2:1 selector in front picks the receive source. The source is either the external serial input or the local transmit serial stream, which gives a wrap (loopback) path.

Character framing is fixed by reset. The framing is moved only when a comma pattern shows up off the current boundary while the realignment enable is high. A flag marks every output character that carries a comma. The receive bus is presented with two complementary clocks, each running at one twentieth of the bit rate. Successive characters are latched alternately by the rising edge of one clock and then the other.

Top module: `comma_rx_deser`

## Requirements
- R1: With no realignment, output character n holds serial bits 10n to 10n+9 counted from the first bit clock after reset. The earliest bit goes into `rxData[0]` and the latest into `rxData[9]`.
- R2: `rxClkA` and `rxClkB` are always complementary. In steady framing each has a period of 20 bit clocks. During and right after reset `rxClkA` is 0 and `rxClkB` is 1.
- R3: Each character gets exactly one rising edge, on `rxClkA` and `rxClkB` in turn. That edge comes 5 bit clocks after `rxData` is updated, and `rxData` is stable at it. The first rising edge after reset is on `rxClkA` and presents the reset value of the bus.
- R4: A comma is a character whose bits 0..6 in serial order are 0011111 or 1100000. In terms of the bus, `rxData[6:0]` is 7'b1111100 or 7'b0000011.
- R5: `commaFlag` is 1 exactly while `rxData` holds a character with a comma in bits 0..6, whatever the enable. Otherwise it is 0.
- R6: While `alignEn` is 1, a comma that arrives off the current boundary is output as a whole character with its first bit in bit 0. The characters after it follow the new framing. One or more characters before it may be corrupted or dropped.
- R7: While `alignEn` is 0, the framing never moves. A comma off the boundary is passed on split across characters and is not flagged.
- R8: With `wrapSel` = 1 the characters are built from `loopIn` and `serialIn` is ignored. With `wrapSel` = 0 they are built from `serialIn`.
- R9: A synchronous reset clears the bit position and the framing. It drives `rxData` to 0 and `commaFlag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | External recovered serial data |
| loopIn | input | 1 | Local transmit serial stream for wrap |
| wrapSel | input | 1 | 1 selects loopIn, 0 selects serialIn |
| alignEn | input | 1 | Enables boundary realignment on commas |
| rxData | output | CHAR_W | Received character, bit 0 earliest |
| rxClkA | output | 1 | Receive clock latching every other character |
| rxClkB | output | 1 | Complement of rxClkA, latches the other characters |
| commaFlag | output | 1 | High while rxData carries a comma |

## Verification
Four properties are checked on every cycle: the two receive clocks are complementary, the bus is stable at each rising receive-clock edge, the flag agrees with the comma content of the bus in both directions, and reset leaves the bus and flag cleared. Only the bench scenarios can show the framing itself. These cover character packing order, the 20-cycle clock period, the strict A/B alternation and the reset-value first edge. They also cover framing that stays put with the enable low, the move onto an off-boundary comma with the enable high, and the source chosen by the wrap selector.

// File: rtl/rxdes_pkg.sv
package rxdes_pkg;

  // Strobes from the framing control to the datapath
  typedef struct packed {
    logic loadChar;  // capture the assembled window as the output character
    logic flipClk;   // toggle the receive clock phase
  } ctlStrobe_t;

endpackage

// File: rtl/rxdes_datapath.sv
module rxdes_datapath
  import rxdes_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              loopIn,
  input  logic              wrapSel,
  input  ctlStrobe_t        strobe,
  output logic              commaNext,
  output logic [CHAR_W-1:0] rxData,
  output logic              commaFlag
);

  localparam int N_PAT = 2;  // true pattern and its complement

  logic              srcBit;
  logic [CHAR_W-2:0] hist;     // older bits, hist[0] is the oldest
  logic [CHAR_W-1:0] nextWin;  // window including the bit sampled now
  logic [N_PAT-1:0]  patHit;

  // Wrap selector in front of the shifter
  always_comb srcBit = wrapSel ? loopIn : serialIn;

  // New bit enters at the top, so bit 0 is the earliest in time
  assign nextWin = {srcBit, hist};

  genvar g;
  generate
    for (g = 0; g < N_PAT; g++) begin : g_pat
      localparam logic [COMMA_W-1:0] PAT = (g == 0) ? COMMA_PAT : ~COMMA_PAT;
      assign patHit[g] = (nextWin[COMMA_W-1:0] == PAT);
    end
  endgenerate

  assign commaNext = |patHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      rxData    <= '0;
      commaFlag <= 1'b0;
    end else begin
      hist <= nextWin[CHAR_W-1:1];
      if (strobe.loadChar) begin
        rxData    <= nextWin;
        commaFlag <= commaNext;
      end
    end
  end

endmodule

// File: rtl/rxdes_ctrl.sv
module rxdes_ctrl
  import rxdes_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       alignEn,
  input  logic       commaNext,
  output ctlStrobe_t strobe,
  output logic       rxClkA,
  output logic       rxClkB
);

  localparam int CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] FLIP_CNT = CNT_W'(CHAR_W / 2 - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             phase;

  // A character closes at the end of the count, or early on a comma when enabled
  always_comb begin
    strobe.loadChar = (bitCnt == LAST_CNT) || (alignEn && commaNext);
    strobe.flipClk  = (bitCnt == FLIP_CNT) && !strobe.loadChar;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      phase  <= 1'b0;
    end else begin
      bitCnt <= strobe.loadChar ? '0 : bitCnt + 1'b1;
      if (strobe.flipClk) phase <= ~phase;
    end
  end

  assign rxClkA = phase;
  assign rxClkB = ~phase;

endmodule

// File: rtl/comma_rx_deser.sv
module comma_rx_deser
  import rxdes_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              loopIn,
  input  logic              wrapSel,
  input  logic              alignEn,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxClkA,
  output logic              rxClkB,
  output logic              commaFlag
);

  ctlStrobe_t strobe;
  logic       commaNext;

  rxdes_datapath #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
  ) u_dp (
    .clk(clk), .rst(rst), .serialIn(serialIn), .loopIn(loopIn),
    .wrapSel(wrapSel), .strobe(strobe), .commaNext(commaNext),
    .rxData(rxData), .commaFlag(commaFlag)
  );

  rxdes_ctrl #(
    .CHAR_W(CHAR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .alignEn(alignEn), .commaNext(commaNext),
    .strobe(strobe), .rxClkA(rxClkA), .rxClkB(rxClkB)
  );

endmodule

// File: rtl/comma_rx_deser_chk.sv
module comma_rx_deser_chk #(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst,
  input logic [CHAR_W-1:0] rxData,
  input logic              rxClkA,
  input logic              rxClkB,
  input logic              commaFlag
);

  logic rstQ;
  logic busHasComma;

  always_ff @(posedge clk) rstQ <= rst;

  assign busHasComma = (rxData[COMMA_W-1:0] == COMMA_PAT) ||
                       (rxData[COMMA_W-1:0] == ~COMMA_PAT);

  assert_clk_complement_R2: assert property (@(posedge clk) disable iff (rst)
    rxClkA != rxClkB)
    else $error("receive clocks not complementary");

  assert_data_stable_at_edge_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rxClkA) || $rose(rxClkB)) |-> $stable(rxData))
    else $error("rxData changed on a receive clock edge");

  assert_flag_implies_comma_R5: assert property (@(posedge clk) disable iff (rst)
    commaFlag |-> busHasComma)
    else $error("comma flag without comma on bus");

  assert_comma_implies_flag_R5: assert property (@(posedge clk) disable iff (rst)
    busHasComma |-> commaFlag)
    else $error("comma on bus without flag");

  // R9: one cycle after a reset edge the bus and flag are clear
  always @(posedge clk) begin
    if (rstQ) begin
      assert_reset_clear_R9: assert (commaFlag == 1'b0 && rxData == '0)
        else $error("reset did not clear outputs");
    end
  end

endmodule

bind comma_rx_deser comma_rx_deser_chk #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) u_chk (
  .clk(clk), .rst(rst), .rxData(rxData), .rxClkA(rxClkA),
  .rxClkB(rxClkB), .commaFlag(commaFlag)
);

// File: tb/sim_comma_rx_deser.sv
module sim_comma_rx_deser;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b0;
  logic       loopIn = 1'b0;
  logic       wrapSel = 1'b0;
  logic       alignEn = 1'b0;
  logic [9:0] rxData;
  logic       rxClkA, rxClkB, commaFlag;

  always #2.5 clk = ~clk;  // 200 MHz

  comma_rx_deser u0 (
    .clk(clk), .rst(rst), .serialIn(serialIn), .loopIn(loopIn),
    .wrapSel(wrapSel), .alignEn(alignEn), .rxData(rxData),
    .rxClkA(rxClkA), .rxClkB(rxClkB), .commaFlag(commaFlag)
  );

  localparam logic [9:0] K_POS = 10'h17C;  // serial 0011111010
  localparam logic [9:0] K_NEG = 10'h283;  // complement
  localparam logic [9:0] D_A = 10'h155;
  localparam logic [9:0] D_B = 10'h2AA;
  localparam logic [9:0] D_C = 10'h333;
  localparam logic [9:0] D_D = 10'h0CC;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  logic [9:0] expData[$];
  bit         expFlag[$];
  bit         expDc[$];
  string      expReq[$];

  logic [9:0] accum;
  int         nbits = 0;
  bit         autoMode = 0;
  string      curReq = "R1";
  bit         lastBit = 0;
  bit         haveLast = 0;
  bit         lastWasA = 0;
  bit         haveARise = 0;
  bit         periodCheck = 0;
  int         lastARise = 0;
  bit         isA;
  logic [9:0] popData;
  bit         popFlag, popDc;
  string      popReq;

  always @(posedge clk) cyc++;

  function automatic bit isComma(logic [9:0] c);
    return (c[6:0] == 7'b1111100) || (c[6:0] == 7'b0000011);
  endfunction

  task automatic check(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic pushExp(logic [9:0] d, bit f, bit dc, string r);
    expData.push_back(d);
    expFlag.push_back(f);
    expDc.push_back(dc);
    expReq.push_back(r);
  endtask

  task automatic sendBit(bit b);
    if (wrapSel) begin loopIn = b; serialIn = ~b; end
    else begin serialIn = b; loopIn = ~b; end
    accum[nbits] = b;
    nbits++;
    lastBit = b;
    if (nbits == 10) begin
      if (autoMode) pushExp(accum, isComma(accum), 1'b0, curReq);
      nbits = 0;
    end
    @(negedge clk);
  endtask

  task automatic sendChar(logic [9:0] c);
    for (int i = 0; i < 10; i++) sendBit(c[i]);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expData.delete(); expFlag.delete(); expDc.delete(); expReq.delete();
    nbits = 0; haveLast = 0; haveARise = 0;
    check(rxData == 10'h0, "R9", "rxData in reset", rxData, 0);
    check(commaFlag == 1'b0, "R9", "commaFlag in reset", commaFlag, 0);
    check(rxClkA == 1'b0 && rxClkB == 1'b1, "R2", "clocks in reset",
          {rxClkA, rxClkB}, 1);
    pushExp(10'h0, 1'b0, 1'b0, "R3");  // first A edge shows reset bus
    rst = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    autoMode = 0;
    while (expData.size() > 0 && guard < 60) begin
      sendBit(~lastBit);
      guard++;
    end
    check(expData.size() == 0, "R3", "characters not delivered", expData.size(), 0);
  endtask

  // Monitor: one expected item per rising receive clock edge
  always @(posedge rxClkA or posedge rxClkB) begin
    #1;
    if (!rst && expData.size() > 0) begin
      isA = rxClkA;
      if (haveLast)
        check(isA != lastWasA, "R3", "clock alternation", isA, !lastWasA);
      lastWasA = isA;
      haveLast = 1;
      if (isA) begin
        if (haveARise && periodCheck)
          check(cyc - lastARise == 20, "R2", "rxClkA period", cyc - lastARise, 20);
        lastARise = cyc;
        haveARise = 1;
      end
      popData = expData.pop_front();
      popFlag = expFlag.pop_front();
      popDc = expDc.pop_front();
      popReq = expReq.pop_front();
      if (!popDc) check(rxData == popData, popReq, "rxData", rxData, popData);
      check(commaFlag == popFlag, popReq, "commaFlag", commaFlag, popFlag);
    end
  end

  initial begin
    // R1: fixed framing, bit order, steady clock period
    alignEn = 0; wrapSel = 0;
    resetDut();
    periodCheck = 1; curReq = "R1"; autoMode = 1;
    sendChar(D_A); sendChar(D_B); sendChar(D_C); sendChar(D_D); sendChar(D_A);
    drain();
    periodCheck = 0;

    // R4/R5: both comma polarities on the boundary, enable low
    resetDut();
    curReq = "R5"; autoMode = 1;
    sendChar(D_A); sendChar(K_POS); sendChar(D_B);
    curReq = "R4";
    sendChar(K_NEG); sendChar(D_A);
    drain();

    // R7: comma off the boundary with enable low is not realigned or flagged
    resetDut();
    curReq = "R7"; autoMode = 1;
    sendBit(0); sendBit(1); sendBit(0);
    sendChar(D_A); sendChar(D_A); sendChar(K_POS); sendChar(D_A); sendChar(D_A);
    drain();

    // R6: enable high realigns onto the comma
    alignEn = 1;
    resetDut();
    autoMode = 0;
    pushExp(10'h0, 1'b0, 1'b1, "R6");
    pushExp(10'h0, 1'b0, 1'b1, "R6");
    pushExp(K_POS, 1'b1, 1'b0, "R6");
    pushExp(D_A, 1'b0, 1'b0, "R6");
    pushExp(D_A, 1'b0, 1'b0, "R6");
    sendBit(0); sendBit(1); sendBit(0);
    sendChar(D_A); sendChar(D_A); sendChar(K_POS); sendChar(D_A); sendChar(D_A);
    drain();

    // R6: enable high with commas already on the boundary keeps framing
    resetDut();
    curReq = "R6"; autoMode = 1;
    sendChar(D_C); sendChar(K_POS); sendChar(D_B); sendChar(K_NEG); sendChar(D_A);
    drain();

    // R8: wrap source selected, serialIn carries the inverse
    alignEn = 0; wrapSel = 1;
    resetDut();
    curReq = "R8"; autoMode = 1;
    sendChar(D_B); sendChar(K_POS); sendChar(D_C); sendChar(D_A);
    drain();
    wrapSel = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule